// File: doc/BRIEF.md
# Temperature Limit Alert Controller

This block watches a set of temperature channels and raises an active-low alert when readings leave their programmed window. Each channel brings an 8-bit two's-complement reading, a high limit, a low limit, a thermal-shutdown limit and a diode-fault flag. One hysteresis value is shared by all channels. Readings are compared only on cycles where the shared valid strobe is high. Per-channel status bits record what was seen. A read strobe stands in for a status-register read.

A mode input sets how the alert pin behaves. In interrupt mode, status bits are sticky. The alert stays low until a read clears every bit whose condition has gone away, and a global mask can force the pin off. In comparator mode, the alert follows a hysteretic thermostat on the high limits only. It ignores the global mask and clears its own high-limit status when it releases.

A second hysteretic comparator drives a thermal-shutdown pin against the per-channel shutdown limits. It keeps its own self-clearing status. The open-drain driver is modelled as a logic level.

Top module: `temp_alert_ctrl`

## Requirements
- R1: After reset, alert_n and therm_n are 1 and every status bit is 0.
- R2: With cfg_comp_mode = 0 (interrupt), a valid strobe sets stat_high[i] when reading i is signed-greater than its high limit and stat_low[i] when it is signed-less than its low limit; alert_n is low right after that clock edge.
- R3: In interrupt mode, status bits stay set after the condition goes away. A read clears only bits whose most recently evaluated condition is false, and alert_n returns high right after that clearing edge.
- R4: In interrupt mode, a diode-fault flag sampled with valid sets stat_fault[i] and pulls alert_n low.
- R5: In interrupt mode, cfg_mask_all = 1 holds alert_n high while status keeps updating; clearing it lets the pending status drive alert_n low again.
- R6: A per-channel mask bit removes that channel from the alert in both modes. In interrupt mode its status is still recorded; in comparator mode its high status is not set.
- R7: With cfg_comp_mode = 1 (comparator), alert_n goes low when any unmasked reading exceeds its high limit. It goes high only when every unmasked reading is below high minus hysteresis, and it holds its level otherwise.
- R8: In comparator mode, stat_high bits of tripping channels are set while the alert is active. Reads do not clear them, they clear when the alert releases, and cfg_mask_all has no effect.
- R9: therm_n follows the same hysteretic rule against the shutdown limits and ignores all masks. stat_therm bits are set for channels above their shutdown limit, survive reads, and clear when therm_n releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_comp_mode | input | 1 | 0 = interrupt mode, 1 = comparator mode |
| cfg_mask_all | input | 1 | Global alert mask (interrupt mode only) |
| ch_mask | input | NCH | Per-channel alert mask |
| meas_valid | input | 1 | Readings are compared this cycle |
| meas_temp | input | NCH*TW | Readings, channel 0 in the low bits |
| lim_high | input | NCH*TW | High limits |
| lim_low | input | NCH*TW | Low limits |
| lim_therm | input | NCH*TW | Thermal-shutdown limits |
| hyst | input | TW | Shared hysteresis |
| diode_fault | input | NCH | Per-channel diode-fault flags |
| stat_rd | input | 1 | Status read strobe |
| alert_n | output | 1 | Active-low alert level |
| therm_n | output | 1 | Active-low thermal-shutdown level |
| stat_high | output | NCH | High-limit status |
| stat_low | output | NCH | Low-limit status |
| stat_fault | output | NCH | Diode-fault status |
| stat_therm | output | NCH | Shutdown status |

## Verification
Every result is due one clock edge after its stimulus. Status, comparator state and both pins are registered on the edge that samples meas_valid or stat_rd. The mask inputs reach alert_n with no register, so a mask change shows up before the next edge. The bench drives inputs 1 ns after a rising edge and samples outputs 1 ns after the next one. Its hysteresis model is stepped once per strobe, so the expected pin level always refers to the same edge as the design.

// File: rtl/tac_pkg.sv
// Package: shared mode encoding for the temperature limit alert controller.
// Assumes: one configuration bit selects the alert behaviour.
package tac_pkg;
    typedef enum logic {
        MODE_INTR = 1'b0,
        MODE_COMP = 1'b1
    } tac_mode_e;
endpackage

// File: rtl/tac_chan_cmp.sv
// Module: signed comparisons for one channel against its limits.
// Assumes: all values are TW-bit two's complement. Thresholds are formed
// one bit wider so that limit minus hysteresis cannot wrap.
module tac_chan_cmp #(
    parameter int TW = 8
) (
    input  logic [TW-1:0] temp,
    input  logic [TW-1:0] hi,
    input  logic [TW-1:0] lo,
    input  logic [TW-1:0] th,
    input  logic [TW-1:0] hy,
    output logic          over_hi,
    output logic          under_lo,
    output logic          rel_hi,
    output logic          over_th,
    output logic          rel_th
);
    localparam int XW = TW + 1;

    logic signed [XW-1:0] t_x, hi_x, lo_x, th_x, hy_x;

    // widen every operand with its sign bit
    always_comb begin
        t_x  = $signed({temp[TW-1], temp});
        hi_x = $signed({hi[TW-1], hi});
        lo_x = $signed({lo[TW-1], lo});
        th_x = $signed({th[TW-1], th});
        hy_x = $signed({hy[TW-1], hy});
    end

    // trip and release decisions
    always_comb begin
        over_hi  = t_x > hi_x;
        under_lo = t_x < lo_x;
        rel_hi   = t_x < (hi_x - hy_x);
        over_th  = t_x > th_x;
        rel_th   = t_x < (th_x - hy_x);
    end
endmodule

// File: rtl/tac_hyst_trip.sv
// Module: hysteretic trip flag shared by several channels.
// Assumes: trip/rel are only meaningful when valid is high. Trip wins over
// release; between the two thresholds the flag holds.
module tac_hyst_trip #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid,
    input  logic [N-1:0] trip,
    input  logic [N-1:0] rel,
    output logic         active,
    output logic         fall
);
    logic set_now;

    // decide set and release for this strobe
    always_comb begin
        set_now = valid & (|trip);
        fall    = valid & active & ~(|trip) & (&rel);
    end

    // trip flag register
    always_ff @(posedge clk) begin
        if (!rst_n)       active <= 1'b0;
        else if (set_now) active <= 1'b1;
        else if (fall)    active <= 1'b0;
    end

    // R7
    // trip_sets_active_chk
    trip_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (|trip)) |=> active);

    // R7
    // rise_needs_valid_chk
    rise_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(valid));
endmodule

// File: rtl/tac_status.sv
// Module: status registers for all channels.
// Assumes: low and fault bits are always sticky and read-cleared. High bits
// are sticky in interrupt mode and self-clearing in comparator mode.
// Shutdown bits always self-clear. A new condition wins over a clear.
module tac_status #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid,
    input  logic         comp_mode,
    input  logic         rd,
    input  logic [N-1:0] ch_mask,
    input  logic [N-1:0] over_hi,
    input  logic [N-1:0] under_lo,
    input  logic [N-1:0] fault,
    input  logic [N-1:0] over_th,
    input  logic         alert_fall,
    input  logic         therm_fall,
    output logic [N-1:0] stat_hi,
    output logic [N-1:0] stat_lo,
    output logic [N-1:0] stat_flt,
    output logic [N-1:0] stat_th
);
    logic [N-1:0] cur_hi, cur_lo, cur_flt;
    logic [N-1:0] clr_hi, clr_lo, clr_flt;
    logic [N-1:0] set_hi, set_lo, set_flt, set_th;
    logic [N-1:0] hi_d, lo_d, flt_d, th_d;

    // read clears only bits whose last condition is false
    always_comb begin
        clr_hi  = rd ? ~cur_hi  : '0;
        clr_lo  = rd ? ~cur_lo  : '0;
        clr_flt = rd ? ~cur_flt : '0;
        set_hi  = valid ? (comp_mode ? (over_hi & ~ch_mask) : over_hi) : '0;
        set_lo  = valid ? under_lo : '0;
        set_flt = valid ? fault    : '0;
        set_th  = valid ? over_th  : '0;
    end

    // next-state selection per mode
    always_comb begin
        lo_d  = (stat_lo  & ~clr_lo)  | set_lo;
        flt_d = (stat_flt & ~clr_flt) | set_flt;
        if (comp_mode) hi_d = alert_fall ? '0 : (stat_hi | set_hi);
        else           hi_d = (stat_hi & ~clr_hi) | set_hi;
        th_d = therm_fall ? '0 : (stat_th | set_th);
    end

    // status and last-condition registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_hi <= '0; stat_lo <= '0; stat_flt <= '0; stat_th <= '0;
            cur_hi  <= '0; cur_lo  <= '0; cur_flt  <= '0;
        end else begin
            stat_hi <= hi_d; stat_lo <= lo_d; stat_flt <= flt_d; stat_th <= th_d;
            if (valid) begin
                cur_hi  <= over_hi;
                cur_lo  <= under_lo;
                cur_flt <= fault;
            end
        end
    end

    // R3
    // low_clear_needs_read_chk
    low_clear_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(stat_lo) & ~stat_lo)) |-> $past(rd));

    // R4
    // fault_clear_needs_read_chk
    fault_clear_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(stat_flt) & ~stat_flt)) |-> $past(rd));
endmodule

// File: rtl/temp_alert_ctrl.sv
// Module: temperature limit alert controller (top).
// Assumes: NCH channels of TW-bit signed readings packed with channel 0 in the
// low bits; comparisons happen only on meas_valid; pins are active-low levels.
module temp_alert_ctrl
    import tac_pkg::*;
#(
    parameter int NCH = 2,
    parameter int TW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_comp_mode,
    input  logic              cfg_mask_all,
    input  logic [NCH-1:0]    ch_mask,
    input  logic              meas_valid,
    input  logic [NCH*TW-1:0] meas_temp,
    input  logic [NCH*TW-1:0] lim_high,
    input  logic [NCH*TW-1:0] lim_low,
    input  logic [NCH*TW-1:0] lim_therm,
    input  logic [TW-1:0]     hyst,
    input  logic [NCH-1:0]    diode_fault,
    input  logic              stat_rd,
    output logic              alert_n,
    output logic              therm_n,
    output logic [NCH-1:0]    stat_high,
    output logic [NCH-1:0]    stat_low,
    output logic [NCH-1:0]    stat_fault,
    output logic [NCH-1:0]    stat_therm
);
    tac_mode_e      mode;
    logic [NCH-1:0] over_hi, under_lo, rel_hi, over_th, rel_th;
    logic [NCH-1:0] a_trip, a_rel;
    logic           comp_active, comp_fall, therm_active, therm_fall;
    logic           intr_alert;

    assign mode = tac_mode_e'(cfg_comp_mode);

    // one comparator slice per channel
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tac_chan_cmp #(.TW(TW)) i_cmp (
            .temp     (meas_temp[g*TW +: TW]),
            .hi       (lim_high[g*TW +: TW]),
            .lo       (lim_low[g*TW +: TW]),
            .th       (lim_therm[g*TW +: TW]),
            .hy       (hyst),
            .over_hi  (over_hi[g]),
            .under_lo (under_lo[g]),
            .rel_hi   (rel_hi[g]),
            .over_th  (over_th[g]),
            .rel_th   (rel_th[g])
        );
    end

    // masked channels never trip and always count as released
    always_comb begin
        a_trip = over_hi & ~ch_mask;
        a_rel  = rel_hi | ch_mask;
    end

    tac_hyst_trip #(.N(NCH)) i_alert_trip (
        .clk(clk), .rst_n(rst_n), .valid(meas_valid),
        .trip(a_trip), .rel(a_rel), .active(comp_active), .fall(comp_fall)
    );

    tac_hyst_trip #(.N(NCH)) i_therm_trip (
        .clk(clk), .rst_n(rst_n), .valid(meas_valid),
        .trip(over_th), .rel(rel_th), .active(therm_active), .fall(therm_fall)
    );

    tac_status #(.N(NCH)) i_status (
        .clk(clk), .rst_n(rst_n), .valid(meas_valid),
        .comp_mode(mode == MODE_COMP), .rd(stat_rd), .ch_mask(ch_mask),
        .over_hi(over_hi), .under_lo(under_lo), .fault(diode_fault),
        .over_th(over_th), .alert_fall(comp_fall), .therm_fall(therm_fall),
        .stat_hi(stat_high), .stat_lo(stat_low), .stat_flt(stat_fault),
        .stat_th(stat_therm)
    );

    // pin levels from registered state and masks
    always_comb begin
        intr_alert = ~cfg_mask_all & (|((stat_high | stat_low | stat_fault) & ~ch_mask));
        alert_n    = (mode == MODE_COMP) ? ~comp_active : ~intr_alert;
        therm_n    = ~therm_active;
    end

    // R9
    // therm_status_idle_chk
    therm_status_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !therm_active |-> (stat_therm == '0));

    // R2
    // intr_alert_has_cause_chk
    intr_alert_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_comp_mode && !alert_n) |-> (|(stat_high | stat_low | stat_fault)));
endmodule

// File: tb/test_temp_alert_ctrl.sv
// Bench: sweeps readings in both modes and compares against arithmetic models.
module test_temp_alert_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam int TW  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_comp_mode = 1'b0, cfg_mask_all = 1'b0;
    logic [NCH-1:0] ch_mask = '0, diode_fault = '0;
    logic meas_valid = 1'b0, stat_rd = 1'b0;
    logic [NCH*TW-1:0] meas_temp = '0, lim_high = '0, lim_low = '0, lim_therm = '0;
    logic [TW-1:0] hyst = '0;
    logic alert_n, therm_n;
    logic [NCH-1:0] stat_high, stat_low, stat_fault, stat_therm;

    int n_run = 0, n_fail = 0;

    temp_alert_ctrl #(.NCH(NCH), .TW(TW)) i_temp_alert_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_comp_mode(cfg_comp_mode),
        .cfg_mask_all(cfg_mask_all), .ch_mask(ch_mask), .meas_valid(meas_valid),
        .meas_temp(meas_temp), .lim_high(lim_high), .lim_low(lim_low),
        .lim_therm(lim_therm), .hyst(hyst), .diode_fault(diode_fault),
        .stat_rd(stat_rd), .alert_n(alert_n), .therm_n(therm_n),
        .stat_high(stat_high), .stat_low(stat_low), .stat_fault(stat_fault),
        .stat_therm(stat_therm)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic strobe(input logic [7:0] t0, input logic [7:0] t1);
        meas_temp = {t1, t0};
        meas_valid = 1'b1;
        @(posedge clk); #1;
        meas_valid = 1'b0;
    endtask

    task automatic do_read();
        stat_rd = 1'b1;
        @(posedge clk); #1;
        stat_rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic act;
        lim_high  = {8'sd127, 8'sd40};
        lim_low   = {-8'sd128, -8'sd10};
        lim_therm = {8'sd127, 8'sd60};
        hyst      = 8'd5;
        #1 do_reset();

        // R1 reset state
        check("R1 alert_n", alert_n, 1);
        check("R1 therm_n", therm_n, 1);
        check("R1 status", {stat_high, stat_low, stat_fault, stat_therm}, 0);

        // R2/R3 interrupt sweep over signed readings on channel 0
        for (int v = -128; v <= 127; v += 5) begin
            logic [7:0] t = v[7:0];
            logic eh = (v > 40), el = (v < -10);
            strobe(t, 8'd0);
            check("R2 stat_high", stat_high[0], eh);
            check("R2 stat_low", stat_low[0], el);
            check("R2 alert_n", alert_n, !(eh || el));
            strobe(8'd0, 8'd0);
            check("R3 sticky high", stat_high[0], eh);
            check("R3 sticky alert", alert_n, !(eh || el));
            do_read();
            check("R3 cleared", {stat_high, stat_low}, 0);
            check("R3 alert released", alert_n, 1);
        end

        // R3 read while condition persists keeps the bit
        strobe(8'd50, 8'd0);
        do_read();
        check("R3 persist bit", stat_high[0], 1);
        check("R3 persist alert", alert_n, 0);
        strobe(8'd0, 8'd0); do_read();

        // R5 global mask in interrupt mode
        cfg_mask_all = 1'b1;
        strobe(8'd50, 8'd0);
        check("R5 status updates", stat_high[0], 1);
        check("R5 masked alert", alert_n, 1);
        cfg_mask_all = 1'b0; #1;
        check("R5 unmasked alert", alert_n, 0);
        strobe(8'd0, 8'd0); do_read();

        // R4 diode fault on channel 1
        diode_fault = 2'b10;
        strobe(8'd0, 8'd0);
        diode_fault = 2'b00;
        check("R4 fault status", stat_fault, 2'b10);
        check("R4 fault alert", alert_n, 0);
        strobe(8'd0, 8'd0); do_read();
        check("R4 fault cleared", stat_fault, 0);

        // R6 channel mask in interrupt mode
        ch_mask = 2'b01;
        strobe(8'd50, 8'd0);
        check("R6 intr status kept", stat_high[0], 1);
        check("R6 intr alert", alert_n, 1);
        ch_mask = 2'b00;

        // R7/R8 comparator sweep, global mask and reads have no effect
        cfg_comp_mode = 1'b1; cfg_mask_all = 1'b1;
        do_reset();
        act = 1'b0;
        for (int k = 0; k < 52; k++) begin
            int v = (k < 26) ? 25 + k : 75 - k;
            act = (v > 40) ? 1'b1 : ((v < 35) ? 1'b0 : act);
            strobe(v[7:0], 8'd0);
            check("R7 comp alert_n", alert_n, !act);
            do_read();
            check("R8 comp stat_high", stat_high[0], act);
        end
        cfg_mask_all = 1'b0;

        // R6 channel mask in comparator mode
        ch_mask = 2'b01;
        strobe(8'd50, 8'd0);
        check("R6 comp alert", alert_n, 1);
        check("R6 comp status", stat_high[0], 0);
        ch_mask = 2'b00;

        // R7 hold until every channel is released
        lim_high = {8'sd20, 8'sd40};
        strobe(8'd50, 8'd18);
        check("R7 two-ch trip", alert_n, 0);
        strobe(8'd0, 8'd18);
        check("R7 two-ch hold", alert_n, 0);
        strobe(8'd0, 8'd10);
        check("R7 two-ch release", alert_n, 1);
        check("R8 release clears", stat_high, 0);
        lim_high = {8'sd127, 8'sd40};

        // R9 shutdown sweep with every mask set and reads each step
        cfg_comp_mode = 1'b0; cfg_mask_all = 1'b1; ch_mask = 2'b11;
        do_reset();
        act = 1'b0;
        for (int k = 0; k < 42; k++) begin
            int v = (k < 21) ? 50 + k : 90 - k;
            act = (v > 60) ? 1'b1 : ((v < 55) ? 1'b0 : act);
            strobe(v[7:0], 8'd0);
            check("R9 therm_n", therm_n, !act);
            do_read();
            check("R9 stat_therm", stat_therm[0], act);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule